// File: doc/BRIEF.md
# Statistics Update Scheduler

This block decides when a statistics snapshot should go to the host for each of a few statistics sessions. Software opens a session with a setup request. The request names a context identifier, a statistics type, an update policy and an interval. The block answers with a handle, and later get and delete requests use that handle.

Each time a session needs an update, the block raises a one-cycle transfer pulse. The pulse carries the session's handle, type and context. The block then waits for a done acknowledge before it issues another transfer. Gathering the counters and moving them to memory is the job of the logic downstream.

There are three policies:
- **Request-only:** a session updates only when a get request names it.
- **Periodic:** a session updates every N prescaled ticks, and also on a get request.
- **One-shot:** a session produces exactly one update and then frees its slot.

Top module: `stat_sched`

## Requirements
- R1: A setup (req_op 0) with a valid mode and type, when a slot is free, returns rsp_ok=1 and rsp_handle equal to the lowest free slot index.
- R2: A setup whose mode code is 0 or 4..7 returns rsp_ok=0 and allocates no slot. Mode codes: 1 request-only, 2 periodic, 3 one-shot.
- R3: A setup whose type code is 0 or 5..7 returns rsp_ok=0 and allocates no slot. Valid types are 1 to 4, and the type is carried unchanged on xfer_type.
- R4: A setup when every slot is in use returns rsp_ok=0.
- R5: A request-only session makes no transfer on ticks. A get (req_op 1) naming it makes one transfer.
- R6: A periodic session with interval N>0 makes one transfer per N ticks, and its count is frozen while its own transfer is outstanding. With N=0 it transfers only on get.
- R7: A one-shot session makes one transfer soon after setup without any get. After that transfer's done, the handle is unallocated, so a get on it fails.
- R8: A get or delete naming an unallocated handle returns rsp_ok=0. Op code 3 always returns rsp_ok=0.
- R9: A delete (req_op 2) on an allocated handle returns rsp_ok=1, frees the slot and stops the session's periodic transfers.
- R10: xfer_valid is a one-cycle pulse carrying the session's handle, type and context. No further pulse occurs until xfer_done has been seen for the previous one.
- R11: When several sessions are pending, they are granted one at a time in round-robin order, starting after the last granted handle.
- R12: Several updates that fall due for one session while a transfer is outstanding merge into a single later transfer.
- R13: Every request gets exactly one response, with rsp_valid high in the cycle after req_valid. rsp_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled interval tick |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 setup, 1 get, 2 delete, 3 reserved |
| req_handle | input | HW | Handle for get or delete |
| req_ctx | input | CTXW | Context identifier for setup |
| req_type | input | 3 | Statistics type for setup |
| req_mode | input | 3 | Update policy for setup |
| req_interval | input | INTW | Interval in ticks for setup |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Request accepted |
| rsp_handle | output | HW | Allocated or named handle |
| xfer_valid | output | 1 | Transfer request pulse |
| xfer_handle | output | HW | Session handle of the transfer |
| xfer_type | output | 3 | Statistics type of the transfer |
| xfer_ctx | output | CTXW | Context identifier of the transfer |
| xfer_done | input | 1 | Acknowledge that the outstanding transfer finished |

## Verification
If a slot's allocation bit is lost or stale, the wrong handle comes back from the next setup. It also shows as a fail or success from the very next get or delete on that handle, one cycle after the request. A corrupted tick count or pending bit shows as too many or too few transfer pulses over a known tick train, within one interval. A broken grant pointer or outstanding flag shows at once as a wrong handle order, or as a pulse before done, when several sessions are kept pending behind a held acknowledge.

// File: rtl/stat_sched.sv
module stat_sched #(
  parameter int NSLOT = 4,
  parameter int CTXW  = 16,
  parameter int INTW  = 16,
  localparam int HW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [HW-1:0]   req_handle,
  input  logic [CTXW-1:0] req_ctx,
  input  logic [2:0]      req_type,
  input  logic [2:0]      req_mode,
  input  logic [INTW-1:0] req_interval,
  output logic            rsp_valid,
  output logic            rsp_ok,
  output logic [HW-1:0]   rsp_handle,
  output logic            xfer_valid,
  output logic [HW-1:0]   xfer_handle,
  output logic [2:0]      xfer_type,
  output logic [CTXW-1:0] xfer_ctx,
  input  logic            xfer_done
);

  localparam logic [1:0] M_PULL = 2'd1;
  localparam logic [1:0] M_PUSH = 2'd2;
  localparam logic [1:0] M_ONCE = 2'd3;

  logic [NSLOT-1:0] alloc_q, pend_q;
  logic [1:0]       mode_q [NSLOT];
  logic [2:0]       type_q [NSLOT];
  logic [CTXW-1:0]  ctx_q  [NSLOT];
  logic [INTW-1:0]  ivl_q  [NSLOT];
  logic [INTW-1:0]  cnt_q  [NSLOT];
  logic             out_q;
  logic [HW-1:0]    cur_q, rr_q;

  logic             mode_ok, type_ok, hnd_ok;
  logic             free_found, gnt_found;
  logic [HW-1:0]    free_idx, gnt_idx;
  logic [NSLOT-1:0] counting, due;

  assign mode_ok = (req_mode >= 3'd1) && (req_mode <= 3'd3);
  assign type_ok = (req_type >= 3'd1) && (req_type <= 3'd4);
  assign hnd_ok  = (int'(req_handle) < NSLOT) && alloc_q[req_handle];

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!alloc_q[i] && !(out_q && int'(cur_q) == i)) begin
        free_found = 1'b1;
        free_idx   = HW'(i);
      end
    end
  end

  always_comb begin
    gnt_found = 1'b0;
    gnt_idx   = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      int j;
      j = (int'(rr_q) + k) % NSLOT;
      if (pend_q[j]) begin
        gnt_found = 1'b1;
        gnt_idx   = HW'(j);
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign counting[g] = tick && alloc_q[g] && (mode_q[g] == M_PUSH) &&
                         (ivl_q[g] != '0) && !(out_q && int'(cur_q) == g);
    assign due[g]      = counting[g] && (cnt_q[g] == ivl_q[g] - INTW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q     <= '0;
      pend_q      <= '0;
      out_q       <= 1'b0;
      cur_q       <= '0;
      rr_q        <= '0;
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_handle  <= '0;
      xfer_valid  <= 1'b0;
      xfer_handle <= '0;
      xfer_type   <= '0;
      xfer_ctx    <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        mode_q[i] <= '0;
        type_q[i] <= '0;
        ctx_q[i]  <= '0;
        ivl_q[i]  <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      rsp_valid  <= req_valid;
      rsp_ok     <= 1'b0;
      rsp_handle <= req_handle;
      xfer_valid <= 1'b0;

      for (int i = 0; i < NSLOT; i++) begin
        if (counting[i]) begin
          cnt_q[i] <= due[i] ? '0 : cnt_q[i] + INTW'(1);
          if (due[i]) pend_q[i] <= 1'b1;
        end
      end

      if (out_q && xfer_done) begin
        out_q <= 1'b0;
        if (mode_q[cur_q] == M_ONCE) begin
          alloc_q[cur_q] <= 1'b0;
          pend_q[cur_q]  <= 1'b0;
        end
      end

      if (!out_q && gnt_found) begin
        out_q           <= 1'b1;
        cur_q           <= gnt_idx;
        pend_q[gnt_idx] <= 1'b0;
        xfer_valid      <= 1'b1;
        xfer_handle     <= gnt_idx;
        xfer_type       <= type_q[gnt_idx];
        xfer_ctx        <= ctx_q[gnt_idx];
        rr_q            <= (int'(gnt_idx) == NSLOT - 1) ? '0 : gnt_idx + HW'(1);
      end

      if (req_valid) begin
        case (req_op)
          2'd0: if (mode_ok && type_ok && free_found) begin
            alloc_q[free_idx] <= 1'b1;
            pend_q[free_idx]  <= (req_mode[1:0] == M_ONCE);
            mode_q[free_idx]  <= req_mode[1:0];
            type_q[free_idx]  <= req_type;
            ctx_q[free_idx]   <= req_ctx;
            ivl_q[free_idx]   <= req_interval;
            cnt_q[free_idx]   <= '0;
            rsp_ok            <= 1'b1;
            rsp_handle        <= free_idx;
          end
          2'd1: if (hnd_ok) begin
            pend_q[req_handle] <= 1'b1;
            rsp_ok             <= 1'b1;
          end
          2'd2: if (hnd_ok) begin
            alloc_q[req_handle] <= 1'b0;
            pend_q[req_handle]  <= 1'b0;
            rsp_ok              <= 1'b1;
          end
          default: rsp_ok <= 1'b0;
        endcase
      end
    end
  end

  logic unused_mode_pull;
  assign unused_mode_pull = (M_PULL == 2'd1);

endmodule

module stat_sched_chk #(
  parameter int NSLOT = 4,
  localparam int HW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [HW-1:0]    req_handle,
  input logic [2:0]       req_type,
  input logic [2:0]       req_mode,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             xfer_valid,
  input logic             xfer_done,
  input logic [NSLOT-1:0] alloc_q
);

  logic busy_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_seen <= 1'b0;
    else if (xfer_done && (busy_seen || xfer_valid)) busy_seen <= 1'b0;
    else if (xfer_valid) busy_seen <= 1'b1;
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R13
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R13
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && (req_mode == 3'd0 || req_mode >= 3'd4)) |=> !rsp_ok);  // R2
  AST_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && (req_type == 3'd0 || req_type >= 3'd5)) |=> !rsp_ok);  // R3
  AST_FREE_HANDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd0 && (int'(req_handle) >= NSLOT || !alloc_q[req_handle])) |=> !rsp_ok);  // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid);  // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !busy_seen);  // R10

endmodule

bind stat_sched stat_sched_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_handle(req_handle), .req_type(req_type), .req_mode(req_mode),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .xfer_valid(xfer_valid),
  .xfer_done(xfer_done), .alloc_q(alloc_q)
);

// File: tb/sim_stat_sched.sv
module sim_stat_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4;
  localparam int HW = 2;

  logic clk = 0, rst_n = 0, tick = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [HW-1:0] req_handle = 0;
  logic [15:0] req_ctx = 0, req_interval = 0;
  logic [2:0] req_type = 0, req_mode = 0;
  logic rsp_valid, rsp_ok, xfer_valid, xfer_done;
  logic [HW-1:0] rsp_handle, xfer_handle;
  logic [2:0] xfer_type;
  logic [15:0] xfer_ctx;
  logic auto_done = 0, man_done = 0;

  int nchk = 0, nfail = 0, ended = 0;
  int pcnt [NSLOT];
  int seq [32];
  int nseq = 0;
  logic [2:0] last_t;
  logic [15:0] last_c;
  logic ok;
  logic [HW-1:0] hh;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign xfer_done = (auto_done & xfer_valid) | man_done;

  stat_sched u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_op(req_op),
    .req_handle(req_handle), .req_ctx(req_ctx), .req_type(req_type), .req_mode(req_mode),
    .req_interval(req_interval), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_handle(rsp_handle), .xfer_valid(xfer_valid), .xfer_handle(xfer_handle),
    .xfer_type(xfer_type), .xfer_ctx(xfer_ctx), .xfer_done(xfer_done)
  );

  always @(negedge clk) if (rst_n && xfer_valid) begin
    pcnt[xfer_handle] = pcnt[xfer_handle] + 1;
    if (nseq < 32) seq[nseq] = int'(xfer_handle);
    nseq = nseq + 1;
    last_t = xfer_type;
    last_c = xfer_ctx;
  end

  function automatic logic exp_setup_ok(input logic [2:0] m, input logic [2:0] t);
    return (m >= 1 && m <= 3) && (t >= 1 && t <= 4);
  endfunction

  task automatic chk(input logic c, input string tag, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [HW-1:0] h, input logic [15:0] c,
                     input logic [2:0] t, input logic [2:0] m, input logic [15:0] iv);
    @(negedge clk);
    req_valid = 1; req_op = op; req_handle = h; req_ctx = c;
    req_type = t; req_mode = m; req_interval = iv;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R13 rsp_valid", int'(rsp_valid), 1);
    ok = rsp_ok; hh = rsp_handle;
  endtask

  task automatic ticks(input int n, input int gap);
    repeat (n) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_xfer();
    @(negedge clk) man_done = 1;
    @(negedge clk) man_done = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr();
    for (int i = 0; i < NSLOT; i++) pcnt[i] = 0;
    nseq = 0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int n0;
    void'($urandom(32'h5eed));
    clr();
    repeat (3) @(negedge clk);
    chk(xfer_valid === 1'b0 && rsp_valid === 1'b0, "R13 reset idle", int'(xfer_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 / R5 request-only session
    req(0, 0, 16'h1234, 3'd1, 3'd1, 16'd2);
    chk(ok && hh == 0, "R1 first setup", int'(hh), 0);
    ticks(10, 1);
    chk(nseq == 0, "R5 no pulse on ticks", nseq, 0);
    req(1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(nseq == 1 && seq[0] == 0, "R5 get pulse", nseq, 1);
    chk(last_t == 3'd1 && last_c == 16'h1234, "R10 pulse fields", int'(last_c), 16'h1234);
    finish_xfer();

    // R2 / R3 invalid codes
    req(0, 0, 1, 3'd1, 3'd0, 0); chk(!ok, "R2 mode 0", int'(ok), 0);
    req(0, 0, 1, 3'd1, 3'd4, 0); chk(!ok, "R2 mode 4", int'(ok), 0);
    req(0, 0, 1, 3'd0, 3'd1, 0); chk(!ok, "R3 type 0", int'(ok), 0);
    req(0, 0, 1, 3'd5, 3'd1, 0); chk(!ok, "R3 type 5", int'(ok), 0);

    // R8 unallocated handles
    req(1, 3, 0, 0, 0, 0); chk(!ok, "R8 get free", int'(ok), 0);
    req(2, 3, 0, 0, 0, 0); chk(!ok, "R8 delete free", int'(ok), 0);
    req(3, 0, 0, 0, 0, 0); chk(!ok, "R8 reserved op", int'(ok), 0);

    // random setup codes checked against the rule
    auto_done = 1;
    for (int it = 0; it < 40; it++) begin
      logic [2:0] rm, rt;
      rm = 3'($urandom_range(0, 7));
      rt = 3'($urandom_range(0, 7));
      req(0, 0, 16'(it), rt, rm, 16'd0);
      chk(ok == exp_setup_ok(rm, rt), "R2 R3 random setup", int'(ok), int'(exp_setup_ok(rm, rt)));
      if (ok) begin
        chk(hh == 1, "R1 random handle", int'(hh), 1);
        req(2, hh, 0, 0, 0, 0);
        chk(ok, "R9 random delete", int'(ok), 1);
      end
      repeat (4) @(negedge clk);
    end

    // R6 periodic, R9 delete stops it
    clr();
    req(0, 0, 16'h0b0b, 3'd2, 3'd2, 16'd3);
    chk(ok && hh == 1, "R1 push handle", int'(hh), 1);
    ticks(9, 3);
    chk(pcnt[1] == 3, "R6 push count", pcnt[1], 3);
    chk(last_t == 3'd2, "R10 push type", int'(last_t), 2);
    req(2, 1, 0, 0, 0, 0); chk(ok, "R9 delete ok", int'(ok), 1);
    ticks(9, 3);
    chk(pcnt[1] == 3, "R9 no pulse after delete", pcnt[1], 3);

    // R6 interval zero
    clr();
    req(0, 0, 16'h0c0c, 3'd4, 3'd2, 16'd0);
    chk(ok && hh == 1, "R1 push0 handle", int'(hh), 1);
    ticks(6, 1);
    chk(nseq == 0, "R6 interval zero ticks", nseq, 0);
    req(1, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(nseq == 1, "R6 interval zero get", nseq, 1);
    req(2, 1, 0, 0, 0, 0);

    // R7 one-shot
    clr();
    req(0, 0, 16'h0d0d, 3'd3, 3'd3, 16'd0);
    chk(ok && hh == 1, "R1 once handle", int'(hh), 1);
    repeat (6) @(negedge clk);
    chk(nseq == 1 && last_t == 3'd3, "R7 single pulse", nseq, 1);
    req(1, 1, 0, 0, 0, 0);
    chk(!ok, "R7 freed after done", int'(ok), 0);
    repeat (4) @(negedge clk);
    chk(nseq == 1, "R7 no second pulse", nseq, 1);
    auto_done = 0;

    // R4 fill table
    for (int s = 1; s < NSLOT; s++) begin
      req(0, 0, 16'(s), 3'd1, 3'd1, 0);
      chk(ok && int'(hh) == s, "R1 fill handle", int'(hh), s);
    end
    req(0, 0, 16'h9, 3'd1, 3'd1, 0);
    chk(!ok, "R4 full table", int'(ok), 0);

    // R11 round robin with wrap
    clr();
    req(1, 2, 0, 0, 0, 0);
    req(1, 0, 0, 0, 0, 0);
    req(1, 1, 0, 0, 0, 0);
    req(1, 3, 0, 0, 0, 0);
    repeat (8) @(negedge clk);
    chk(nseq == 1, "R10 held while outstanding", nseq, 1);
    repeat (3) finish_xfer();
    chk(nseq == 4, "R11 rr count", nseq, 4);
    chk(seq[0] == 2 && seq[1] == 3, "R11 rr order a", seq[1], 3);
    chk(seq[2] == 0 && seq[3] == 1, "R11 rr order b", seq[2], 0);
    finish_xfer();

    // R12 coalescing
    clr();
    req(1, 0, 0, 0, 0, 0);
    req(1, 1, 0, 0, 0, 0);
    req(1, 1, 0, 0, 0, 0);
    req(1, 1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    chk(nseq == 1, "R10 no pulse before done", nseq, 1);
    finish_xfer();
    n0 = nseq;
    chk(n0 == 2 && seq[1] == 1, "R12 one merged pulse", n0, 2);
    finish_xfer();
    repeat (10) @(negedge clk);
    chk(nseq == 2, "R12 no extra pulse", nseq, 2);

    summary();
  end
endmodule